// File: doc/BRIEF.md
# Serial SAR Converter Control Frontend

This block holds the digital logic of a two-channel 12-bit successive-approximation converter with a three-wire serial read port. A host pulls the active-low select line low to wake the converter. The level of the serial clock at that falling edge picks the clock mode. Host clocking then gets the conversion done and shifts out a 16-bit frame. The capacitive DAC, the track/hold switch and the comparator are outside the block. The block drives the DAC trial code and the track control, reads the comparator bit back, and drives an oscillator enable that stands in for the on-chip conversion clock.

The controller has four states. OFF is shutdown. TRACK is the acquisition window. CONV runs the twelve binary-weighted trials. READ holds the finished result for shifting out. Its transitions are these:
- OFF goes to TRACK on a select falling edge.
- TRACK goes to CONV on the sampling SCLK fall. That is the first fall in internal mode and the second fall in external mode.
- CONV goes to READ when the trial sequencer reports done.
- Any state other than OFF goes to OFF on a select rising edge. This ends the frame, or aborts an unfinished conversion, and flips the channel.

All inputs are taken as synchronous to `clk`. SCLK and select edges are found by comparing each input with its value one cycle earlier.

Top module: `adc_fe_top`

## Requirements
- R1: After reset, `shdn`=1, `dout_oe`=0, `track`=0, `osc_en`=0 and `chan_sel`=0, so the first conversion uses channel 0.
- R2: The SCLK level at the select falling edge fixes the mode until select rises. High selects internal mode, where `osc_en` rises after the first SCLK fall. Low selects external mode, where `osc_en` never rises.
- R3: `chan_sel` flips at the end of every select cycle, including one with no SCLK activity. Such an empty cycle therefore makes the next conversion repeat the previous channel. `chan_sel` holds its value while select is low.
- R4: In external mode, `track` is 1 from the select fall until the second SCLK fall, and 0 after it. `track` is 0 whenever `shdn`=1.
- R5: In internal mode, `track` drops and `osc_en` rises on the first SCLK fall. `dout` is 0 while the internal conversion runs. After the twelfth oscillator step `osc_en` falls and `dout` goes to 1, which is the end-of-conversion flag.
- R6: The frame value after SCLK fall k (k=1..16) is bit 16-k of {1,1,1,CH,D[11:0]}. CH is the channel bit (0 or 1). In internal mode the first 1 is the end-of-conversion flag. `dout` changes only after an SCLK fall, or when that flag is raised.
- R7: Every SCLK fall after the sixteenth one drives `dout`=0.
- R8: With select high, `dout_oe`=0 and `shdn`=1.
- R9: A select rise before the conversion finishes aborts it. No `conv_done` pulse follows, and the next conversion is unaffected.
- R10: `conv_done` pulses for exactly one cycle, and at that cycle `dac_code` holds the final code. With a comparator that returns 1 when the trial code is not above the input, that final code equals the input level.
- R11: In internal mode, SCLK falls during the conversion are ignored and do not shift the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Active-low select; high means shutdown |
| sclk | input | 1 | Serial clock from the host |
| cmp_in | input | 1 | Comparator result for the current trial code |
| dac_code | output | 12 | Trial code to the capacitive DAC |
| track | output | 1 | Track/hold switch closed (tracking) |
| osc_en | output | 1 | Internal conversion oscillator enable |
| dout | output | 1 | Serial data out |
| dout_oe | output | 1 | Output enable for the tri-state driver of `dout` |
| shdn | output | 1 | Shutdown flag |
| chan_sel | output | 1 | Input multiplexer channel |
| conv_done | output | 1 | One-cycle strobe when a conversion completes |

## Verification
Input levels are swept across the full code range on both channels and in both clock modes. The levels include all-zeros, all-ones and the two codes on either side of mid-scale, where every trial decision flips. The alternating bit patterns catch a trial bit that is kept or cleared in the wrong step. Comparing the same levels in internal and external mode separates faults in the trial sequencing from faults in the frame shifter. An aborted conversion, an empty select cycle and extra SCLK falls during an internal conversion check that the channel toggle and the fall counter are kept separate from the data path.

// File: rtl/adc_fe_pkg.sv
package adc_fe_pkg;
    typedef enum logic [1:0] {
        ST_OFF,
        ST_TRACK,
        ST_CONV,
        ST_READ
    } fe_state_t;
endpackage

// File: rtl/adc_fe_edge.sv
module adc_fe_edge #(
    parameter int N = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= sig;
    end

    assign rise = sig & ~prev_q;
    assign fall = ~sig & prev_q;
endmodule

// File: rtl/adc_fe_sar.sv
module adc_fe_sar #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         step,
    input  logic         abort,
    input  logic         cmp,
    output logic [W-1:0] code,
    output logic         busy,
    output logic         done
);
    localparam int PW = (W > 1) ? $clog2(W) : 1;

    logic [PW-1:0] ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code  <= '0;
            ptr_q <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (abort) begin
                busy <= 1'b0;
                code <= '0;
            end else if (start) begin
                code  <= {1'b1, {(W-1){1'b0}}};
                ptr_q <= PW'(W-1);
                busy  <= 1'b1;
            end else if (busy && step) begin
                code[ptr_q] <= cmp;
                if (ptr_q != '0) begin
                    code[ptr_q - 1'b1] <= 1'b1;
                    ptr_q <= ptr_q - 1'b1;
                end else begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_START_LOADS_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !abort) |=> (code == {1'b1, {(W-1){1'b0}}})); // R10
    AST_ABORT_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !done); // R9
endmodule

// File: rtl/adc_fe_frame.sv
module adc_fe_frame #(
    parameter int W     = 12,
    parameter int LEAD  = 3,
    parameter int CNT_W = 5
) (
    input  logic [CNT_W-1:0] fcnt,
    input  logic             chid,
    input  logic [W-1:0]     code,
    input  logic             blank,
    output logic             bit_out
);
    localparam int LEN = LEAD + 1 + W;
    localparam int IW  = (W > 1) ? $clog2(W) : 1;

    always_comb begin
        int k;
        k = int'(fcnt);
        if (blank || k == 0)   bit_out = 1'b0;
        else if (k <= LEAD)    bit_out = 1'b1;
        else if (k == LEAD+1)  bit_out = chid;
        else if (k <= LEN)     bit_out = code[IW'(LEN - k)];
        else                   bit_out = 1'b0;
    end
endmodule

// File: rtl/adc_fe_top.sv
module adc_fe_top
    import adc_fe_pkg::*;
#(
    parameter int DATA_W          = 12,
    parameter int LEAD_ONES       = 3,
    parameter int EXT_SAMPLE_FALL = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              sclk,
    input  logic              cmp_in,
    output logic [DATA_W-1:0] dac_code,
    output logic              track,
    output logic              osc_en,
    output logic              dout,
    output logic              dout_oe,
    output logic              shdn,
    output logic              chan_sel,
    output logic              conv_done
);
    localparam int FRAME_LEN = LEAD_ONES + 1 + DATA_W;
    localparam int CNT_W     = $clog2(FRAME_LEN + 4);

    fe_state_t        state_q, state_d;
    logic             int_mode_q, chan_q, track_q;
    logic [CNT_W-1:0] fcnt_q;
    logic [1:0]       rise_v, fall_v;
    logic             sel_fall, sel_rise, sclk_fall;
    logic             sar_start, sar_step, sar_abort, sar_busy, sar_done;
    logic             blank, count_en;

    adc_fe_edge #(.N(2), .RST_VAL(2'b10)) u_edge (
        .clk(clk), .rst_n(rst_n), .sig({sel_n, sclk}),
        .rise(rise_v), .fall(fall_v)
    );
    assign sel_rise  = rise_v[1];
    assign sel_fall  = fall_v[1];
    assign sclk_fall = fall_v[0];

    assign sar_start = (state_q == ST_TRACK) && sclk_fall && !sel_rise &&
                       (int_mode_q || fcnt_q == CNT_W'(EXT_SAMPLE_FALL - 1));
    assign sar_step  = (state_q == ST_CONV) && (int_mode_q || sclk_fall);
    assign sar_abort = sel_rise && (state_q != ST_OFF);

    adc_fe_sar #(.W(DATA_W)) u_sar (
        .clk(clk), .rst_n(rst_n), .start(sar_start), .step(sar_step),
        .abort(sar_abort), .cmp(cmp_in), .code(dac_code),
        .busy(sar_busy), .done(sar_done)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   if (sel_fall) state_d = ST_TRACK;
            ST_TRACK: if (sel_rise) state_d = ST_OFF;
                      else if (sar_start) state_d = ST_CONV;
            ST_CONV:  if (sel_rise) state_d = ST_OFF;
                      else if (sar_done) state_d = ST_READ;
            ST_READ:  if (sel_rise) state_d = ST_OFF;
            default:  state_d = ST_OFF;
        endcase
    end

    assign count_en = !((state_q == ST_CONV) && int_mode_q);

    // per-cycle context: mode, channel, fall count, track switch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_mode_q <= 1'b0;
            chan_q     <= 1'b0;
            fcnt_q     <= '0;
            track_q    <= 1'b0;
        end else begin
            if (state_q == ST_OFF) begin
                fcnt_q <= '0;
                if (sel_fall) begin
                    int_mode_q <= sclk;
                    track_q    <= 1'b1;
                end
            end else if (sel_rise) begin
                chan_q  <= ~chan_q;
                track_q <= 1'b0;
            end else begin
                if (sclk_fall && count_en && fcnt_q != '1)
                    fcnt_q <= fcnt_q + 1'b1;
                if (sar_start)
                    track_q <= 1'b0;
            end
        end
    end

    assign blank = int_mode_q && (state_q == ST_CONV);

    adc_fe_frame #(.W(DATA_W), .LEAD(LEAD_ONES), .CNT_W(CNT_W)) u_frame (
        .fcnt(fcnt_q), .chid(chan_q), .code(dac_code),
        .blank(blank), .bit_out(dout)
    );

    // outputs
    always_comb begin
        shdn      = (state_q == ST_OFF);
        dout_oe   = (state_q != ST_OFF);
        osc_en    = (state_q == ST_CONV) && int_mode_q && sar_busy;
        track     = track_q;
        chan_sel  = chan_q;
        conv_done = sar_done;
    end

    AST_HIZ_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n && $past(sel_n)) |-> !dout_oe); // R8
    AST_NO_TRACK_IN_SHDN: assert property (@(posedge clk) disable iff (!rst_n)
        shdn |-> !track); // R4
    AST_OSC_AFTER_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        osc_en |-> !track); // R5
    AST_CHAN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!shdn && !sel_n) |=> $stable(chan_sel)); // R3
    AST_DOUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!shdn && !$past(shdn) && dout != $past(dout)) |->
        ($past(sclk_fall) || $past(sar_done))); // R6
endmodule

// File: tb/sim_adc_fe_top.sv
module sim_adc_fe_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n = 1'b1;
    logic        sclk = 1'b0;
    logic        cmp_in;
    logic [11:0] dac_code;
    logic        track, osc_en, dout, dout_oe, shdn, chan_sel, conv_done;

    logic [11:0] vin0 = 12'd0, vin1 = 12'd0;
    int          checks = 0, errors = 0;
    int          done_cnt = 0;
    logic [11:0] done_code = '0;
    bit          osc_seen = 1'b0;
    bit          exp_ch = 1'b0;

    always #10 clk = ~clk;

    assign cmp_in = (dac_code <= (chan_sel ? vin1 : vin0));

    adc_fe_top u0 (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .cmp_in(cmp_in),
        .dac_code(dac_code), .track(track), .osc_en(osc_en), .dout(dout),
        .dout_oe(dout_oe), .shdn(shdn), .chan_sel(chan_sel), .conv_done(conv_done)
    );

    always @(negedge clk) begin
        if (conv_done) begin
            done_cnt++;
            done_code = dac_code;
        end
        if (osc_en) osc_seen = 1'b1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fall_bit(output logic b);
        sclk = 1'b1; tick(2);
        sclk = 1'b0; tick(1);
        b = dout;
        tick(1);
    endtask

    function automatic logic [15:0] exp_frame(input bit ch, input logic [11:0] v);
        return {3'b111, ch, v};
    endfunction

    task automatic set_vin(input logic [11:0] v);
        if (exp_ch) vin1 = v; else vin0 = v;
    endtask

    task automatic end_cycle();
        sel_n = 1'b1; tick(2);
        chk("R8 oe off", {31'd0, dout_oe}, 32'd0);
        chk("R8 shdn", {31'd0, shdn}, 32'd1);
        exp_ch = ~exp_ch;
        tick(2);
    endtask

    task automatic ext_frame(input logic [11:0] v, input bit extra);
        logic [15:0] got;
        logic        b;
        int          d0;
        set_vin(v);
        d0 = done_cnt;
        osc_seen = 1'b0;
        sclk = 1'b0; sel_n = 1'b0; tick(3);
        chk("R3 chan_sel", {31'd0, chan_sel}, {31'd0, exp_ch});
        chk("R4 track before", {31'd0, track}, 32'd1);
        for (int k = 1; k <= 16; k++) begin
            fall_bit(b);
            got[16-k] = b;
            if (k == 1) chk("R4 track after fall 1", {31'd0, track}, 32'd1);
            if (k == 2) chk("R4 track after fall 2", {31'd0, track}, 32'd0);
        end
        chk("R6 ext frame", {16'd0, got}, {16'd0, exp_frame(exp_ch, v)});
        chk("R2 ext no osc", {31'd0, osc_seen}, 32'd0);
        chk("R10 done count", done_cnt - d0, 32'd1);
        chk("R10 done code", {20'd0, done_code}, {20'd0, v});
        if (extra) begin
            for (int k = 0; k < 3; k++) begin
                fall_bit(b);
                chk("R7 trailing zero", {31'd0, b}, 32'd0);
            end
        end
        end_cycle();
    endtask

    task automatic int_frame(input logic [11:0] v, input bit noise);
        logic [15:0] got;
        logic        b;
        int          d0;
        set_vin(v);
        d0 = done_cnt;
        sclk = 1'b1; sel_n = 1'b0; tick(3);
        chk("R3 chan_sel", {31'd0, chan_sel}, {31'd0, exp_ch});
        sclk = 1'b0; tick(1);
        chk("R5 track off", {31'd0, track}, 32'd0);
        chk("R2 int osc on", {31'd0, osc_en}, 32'd1);
        chk("R5 dout low in conv", {31'd0, dout}, 32'd0);
        if (noise) begin
            sclk = 1'b1; tick(2); sclk = 1'b0; tick(1);
            chk("R11 dout low after ignored fall", {31'd0, dout}, 32'd0);
        end
        tick(16);
        chk("R5 osc off", {31'd0, osc_en}, 32'd0);
        got[15] = dout;
        for (int k = 2; k <= 16; k++) begin
            fall_bit(b);
            got[16-k] = b;
        end
        chk(noise ? "R11 int frame" : "R6 int frame", {16'd0, got},
            {16'd0, exp_frame(exp_ch, v)});
        chk("R10 done code", {20'd0, done_code}, {20'd0, v});
        chk("R10 done count", done_cnt - d0, 32'd1);
        end_cycle();
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic b;
        int   d0;
        tick(3);
        rst_n = 1'b1;
        tick(2);
        chk("R1 shdn", {31'd0, shdn}, 32'd1);
        chk("R1 oe", {31'd0, dout_oe}, 32'd0);
        chk("R1 track", {31'd0, track}, 32'd0);
        chk("R1 osc", {31'd0, osc_en}, 32'd0);
        chk("R1 chan", {31'd0, chan_sel}, 32'd0);

        ext_frame(12'h000, 1'b1);
        ext_frame(12'hFFF, 1'b1);
        int_frame(12'h800, 1'b0);
        int_frame(12'h7FF, 1'b0);
        ext_frame(12'hAAA, 1'b0);
        ext_frame(12'h555, 1'b0);
        int_frame(12'hAAA, 1'b0);
        int_frame(12'h555, 1'b1);

        for (int i = 0; i < 24; i++) begin
            logic [11:0] v;
            v = 12'((i * 173 + 5) % 4096);
            if (i % 2 == 0) ext_frame(v, 1'b0);
            else            int_frame(v, i % 3 == 0);
        end

        // R9: abort external conversion mid-way
        set_vin(12'h123);
        d0 = done_cnt;
        sclk = 1'b0; sel_n = 1'b0; tick(3);
        for (int k = 0; k < 6; k++) fall_bit(b);
        sel_n = 1'b1; tick(2);
        chk("R9 shdn after abort", {31'd0, shdn}, 32'd1);
        tick(20);
        chk("R9 no done after abort", done_cnt - d0, 32'd0);
        exp_ch = ~exp_ch;
        ext_frame(12'h9C3, 1'b0);

        // R9: abort internal conversion
        d0 = done_cnt;
        set_vin(12'h321);
        sclk = 1'b1; sel_n = 1'b0; tick(3);
        sclk = 1'b0; tick(3);
        sel_n = 1'b1; tick(20);
        chk("R9 int abort no done", done_cnt - d0, 32'd0);
        chk("R9 int abort osc off", {31'd0, osc_en}, 32'd0);
        exp_ch = ~exp_ch;
        int_frame(12'h4E7, 1'b0);

        // R3: empty select cycle repeats channel of previous conversion
        sclk = 1'b0; sel_n = 1'b0; tick(3);
        sel_n = 1'b1; tick(3);
        exp_ch = ~exp_ch;
        ext_frame(12'h0F0, 1'b0);
        ext_frame(12'hF0F, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule